// File: doc/BRIEF.md
# Overlapping-Window Approximate Adder

This block adds two N-bit operands without ever building an N-bit carry chain. The operands are cut into K-bit segments. Each output segment above the lowest two is taken from a private 2K-bit adder that sees only that segment and the K bits just below it. A carry that would have to cross more than K bits of the lower neighbour is lost, so the worst path through the block depends on K and not on N. The block has no clock and no state.

Alongside the sum and carry-out, the block gives two flags for each window: whether every bit of the window's lower half propagates, and whether that lower half generates a carry on its own. A later stage can combine these flags with a true carry to find the segments that came out wrong. That stage is not part of this block. With the default N = 16 and K = 4, about 94% of uniformly random operand pairs are summed exactly. A larger K raises that fraction and lengthens the path.

Top module: `ovl_approx_adder`

## Requirements
- R1: Sum bits [2K-1:0] equal the low 2K bits of the exact sum a_i + b_i.
- R2: For each segment j >= 2, sum bits [jK+K-1:jK] equal bits [2K-1:K] of the 2K-bit sum of operand bits [(j-1)K+2K-1:(j-1)K], with a carry-in of zero.
- R3: cout_o equals bit 2K of the (2K+1)-bit sum of the topmost window, which covers operand bits [N-1:N-2K].
- R4: Window i covers operand bits [iK+2K-1:iK], for i = 0 to N/K-2. If no window i >= 1 has its lower half fully propagating while the exact carry into bit iK is 1, then {cout_o, sum_o} equals the exact (N+1)-bit sum.
- R5: win_prop_o[i] is 1 exactly when a_i XOR b_i is all ones over bits [iK+K-1:iK].
- R6: win_gen_o[i] is 1 exactly when the K-bit sum of a_i and b_i over bits [iK+K-1:iK] carries out.
- R7: For N = 16 and K = 4, between 92% and 96% of 4000 uniformly random operand pairs give {cout_o, sum_o} equal to the exact sum.
- R8: The value {cout_o, sum_o} is never greater than the exact sum, because the block only loses carries.
- R9: The same rules R1 to R6 hold for N = 32 and K = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sum_o | output | N | Approximate sum |
| cout_o | output | 1 | Carry out of the topmost window |
| win_prop_o | output | N/K-1 | Lower half of window i fully propagates |
| win_gen_o | output | N/K-1 | Lower half of window i generates a carry |

## Verification
The bound checks assume that K divides N, that N is at least 2K and that K is at least 2. They also assume the operands stay stable between clock edges, because the block is combinational and is sampled on the falling edge. The bench holds to all of this. It runs only the two legal shapes and changes the operands shortly after the rising edge. It drives directed operands chosen to reach the lost-carry case, full ripples and the top carry-out. It then drives uniform random operands, and the measured exact-match rate is compared against its expected band.

// File: rtl/ovl_approx_adder.sv
module ovl_approx_adder #(
  parameter int N = 16,
  parameter int K = 4
) (
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  output logic [N-1:0]     sum_o,
  output logic             cout_o,
  output logic [N/K-2:0]   win_prop_o,
  output logic [N/K-2:0]   win_gen_o
);

  localparam int M = N / K - 1;

  assign sum_o[K-1:0] = a_i[K-1:0] + b_i[K-1:0];

  for (genvar i = 0; i < M; i++) begin : g_win
    logic [K-1:0] lo_a, lo_b, hi_a, hi_b;
    assign lo_a = a_i[i*K +: K];
    assign lo_b = b_i[i*K +: K];
    assign hi_a = a_i[(i+1)*K +: K];
    assign hi_b = b_i[(i+1)*K +: K];

    assign win_prop_o[i] = &(lo_a ^ lo_b);
    assign win_gen_o[i]  = lo_a > ~lo_b;

    if (i == M - 1) begin : g_top
      logic [K:0] hi;
      assign hi = {1'b0, hi_a} + {1'b0, hi_b} + {{K{1'b0}}, win_gen_o[i]};
      assign sum_o[(i+1)*K +: K] = hi[K-1:0];
      assign cout_o = hi[K];
    end else begin : g_mid
      assign sum_o[(i+1)*K +: K] = hi_a + hi_b + {{(K-1){1'b0}}, win_gen_o[i]};
    end
  end

endmodule

// File: rtl/ovl_approx_adder_chk.sv
module ovl_approx_adder_chk #(
  parameter int N = 16,
  parameter int K = 4
) (
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [N-1:0]   sum_o,
  input logic           cout_o,
  input logic [N/K-2:0] win_prop_o,
  input logic [N/K-2:0] win_gen_o
);

  localparam int M = N / K - 1;
  localparam int W = 2 * K;
  localparam logic [N:0] KM = {{(N+1-K){1'b0}}, {K{1'b1}}};

  logic [N:0] ex, carries, lsum;
  logic [W:0] low_ex, top_ex;
  logic [M-1:0] prop_exp, gen_exp;
  logic hazard;

  assign ex      = {1'b0, a_i} + {1'b0, b_i};
  assign carries = ex ^ {1'b0, a_i} ^ {1'b0, b_i};
  assign low_ex  = {1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]};
  assign top_ex  = {1'b0, a_i[N-1 -: W]} + {1'b0, b_i[N-1 -: W]};

  always_comb begin
    hazard = 1'b0;
    lsum = '0;
    prop_exp = '0;
    gen_exp = '0;
    for (int i = 0; i < M; i++) begin
      lsum = (({1'b0, a_i} >> (i*K)) & KM) + (({1'b0, b_i} >> (i*K)) & KM);
      gen_exp[i]  = (lsum >> K) != '0;
      prop_exp[i] = (((({1'b0, a_i} ^ {1'b0, b_i})) >> (i*K)) & KM) == KM;
      if (i > 0 && prop_exp[i] && carries[i*K]) hazard = 1'b1;
    end
  end

  always_comb begin
    assert_low_exact_R1: assert (sum_o[W-1:0] == low_ex[W-1:0]);
    assert_top_carry_R3: assert (cout_o == top_ex[W]);
    assert_exact_when_safe_R4: assert (hazard || {cout_o, sum_o} == ex);
    assert_prop_flags_R5: assert (win_prop_o == prop_exp);
    assert_gen_flags_R6: assert (win_gen_o == gen_exp);
    assert_never_above_R8: assert ({cout_o, sum_o} <= ex);
  end

endmodule

bind ovl_approx_adder ovl_approx_adder_chk #(.N(N), .K(K)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .cout_o(cout_o),
  .win_prop_o(win_prop_o), .win_gen_o(win_gen_o)
);

// File: tb/ovl_approx_adder_bench.sv
module ovl_approx_adder_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic c16;
  logic [2:0] p16, g16;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic c32;
  logic [2:0] p32, g32;

  ovl_approx_adder #(.N(16), .K(4)) u_ovl_approx_adder (
    .a_i(a16), .b_i(b16), .sum_o(s16), .cout_o(c16),
    .win_prop_o(p16), .win_gen_o(g16));

  ovl_approx_adder #(.N(32), .K(8)) u_wide (
    .a_i(a32), .b_i(b32), .sum_o(s32), .cout_o(c32),
    .win_prop_o(p32), .win_gen_o(g32));

  typedef struct {
    logic [63:0] a, b, s, ws;
    logic c, wc, hz;
    logic [7:0] p, g, wp, wg;
    bit rate;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0, exact_hits = 0, rate_n = 0;
  bit done = 0;

  function automatic void model(input int n, input int k, input logic [63:0] a, b,
                                output logic [63:0] s, output logic c,
                                output logic [7:0] p, g, output logic hz);
    logic [63:0] km, wm, carries;
    int m;
    km = (64'd1 << k) - 1;
    wm = (64'd1 << (2*k)) - 1;
    m = n / k - 1;
    carries = (a + b) ^ a ^ b;
    s = (a + b) & wm;
    c = 0; p = 0; g = 0; hz = 0;
    for (int i = 0; i < m; i++) begin
      logic [63:0] wa, wb, wsum;
      wa = (a >> (i*k)) & wm;
      wb = (b >> (i*k)) & wm;
      wsum = wa + wb;
      p[i] = ((wa ^ wb) & km) == km;
      g[i] = (((wa & km) + (wb & km)) >> k) != 0;
      if (i > 0) s = s | (((wsum >> k) & km) << ((i+1)*k));
      if (i == m - 1) c = wsum[2*k];
      if (i > 0 && p[i] && carries[i*k]) hz = 1;
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, b, input logic [31:0] wa, wb, input bit rate);
    item_t it;
    logic hz2;
    @(posedge clk);
    #1;
    a16 = a; b16 = b; a32 = wa; b32 = wb;
    it.a = 64'(a); it.b = 64'(b); it.rate = rate;
    model(16, 4, 64'(a), 64'(b), it.s, it.c, it.p, it.g, it.hz);
    model(32, 8, 64'(wa), 64'(wb), it.ws, it.wc, it.wp, it.wg, hz2);
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [63:0] got, ex;
        it = q.pop_front();
        got = {47'd0, c16, s16};
        ex = it.a + it.b;
        check("R1 low bits", 64'(s16[7:0]), it.s & 64'hFF);
        check("R2 upper segments", 64'(s16[15:8]), (it.s >> 8) & 64'hFF);
        check("R3 carry out", 64'(c16), 64'(it.c));
        check("R5 propagate flags", 64'(p16), 64'(it.p[2:0]));
        check("R6 generate flags", 64'(g16), 64'(it.g[2:0]));
        if (!it.hz) check("R4 exact when no lost carry", got, ex);
        check("R8 not above exact", 64'(got <= ex), 64'd1);
        check("R9 wide sum", 64'(s32), it.ws);
        check("R9 wide carry", 64'(c32), 64'(it.wc));
        check("R9 wide flags", {58'd0, p32, g32}, {58'd0, it.wp[2:0], it.wg[2:0]});
        if (it.rate) begin
          rate_n++;
          if (got == ex) exact_hits++;
        end
      end
    end
  end

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(16'h0000, 16'h0000, 32'h0, 32'h0, 0);
    drive(16'hFFFF, 16'h0001, 32'hFFFF_FFFF, 32'h1, 0);
    drive(16'h00FF, 16'h0001, 32'h0000_FFFF, 32'h1, 0);
    drive(16'h8000, 16'h8000, 32'h8000_0000, 32'h8000_0000, 0);
    drive(16'h1234, 16'h4321, 32'h1234_5678, 32'h8765_4321, 0);
    drive(16'h0F0F, 16'h00F1, 32'h00FF_00FF, 32'h0000_FF01, 0);
    drive(16'hAAAA, 16'h5555, 32'hAAAA_AAAA, 32'h5555_5555, 0);
    for (int n = 0; n < 4000; n++)
      drive(16'($urandom), 16'($urandom), $urandom, $urandom, 1);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    tests++;
    if (exact_hits < 3680 || exact_hits > 3840) begin
      fails++;
      $display("FAIL R7 exact rate: actual %0d of %0d expected 3680..3840", exact_hits, rate_n);
    end
    done = 1;
    finish_up();
  end

endmodule